// File: doc/BRIEF.md
# MSI-X Message Write Generator

This block turns interrupt events from application logic into MSI-X messages. Each message is a memory-write request with one dword of payload, presented on a transmit stream. The block owns a small vector table and a pending-bit array. Software reaches both through a simple dword-addressed register port. Each table slot stores a 64-bit target address, a 32-bit data word and a per-vector mask bit.

Every event first lands in the pending array. A pending vector is sent only when three conditions hold: the MSI-X enable is set, the function-wide mask is clear, and the vector's own mask is clear. When several vectors are eligible, the lowest index goes first. Only one message is in flight at a time. Its header and payload are captured when it is launched and held until the sink accepts it. Back-pressure rules: `tx_valid` stays high and `tx_hdr`/`tx_data` stay unchanged while `tx_ready` is low. A transfer happens on a clock edge where both are high. After each accepted message the stream is idle for at least one cycle.

Register map (dword addresses): vector v occupies dwords 4v..4v+3. Its words are address low, address high, data and control, in that order. The pending array is one read-only dword at address 4*NUM_VEC, with bit v for vector v. NUM_VEC is at most 32.

Top module: `msix_msg_gen`

## Requirements
- R1: After reset `tx_valid` is 0, every vector's control word reads 1 (masked), and the pending dword reads 0.
- R2: Table words read back what was written, except that address-low bits 1:0 always read 0 and control bits 31:1 always read 0; control bit 0 is the vector mask (1 = masked).
- R3: The pending dword at address 4*NUM_VEC is read-only; a write to it leaves its value unchanged.
- R4: Every header has length field (DW0 bits 9:0) = 1, first byte enable (DW1 bits 3:0) = 4'b1111, last byte enable (DW1 bits 7:4) = 4'b0000, requester ID in DW1 bits 31:16, and DW1 bits 15:8 = 0. When the upper address word is zero, the format is 3DW: DW0 = 32'h4000_0001, DW2 = address low, DW3 = 0. DW0 sits at `tx_hdr` bits 31:0 and DWn at bits 32n+31:32n.
- R5: When the upper address word is nonzero, the format is 4DW: DW0 = 32'h6000_0001, DW2 = address high, DW3 = address low.
- R6: The payload `tx_data` equals the vector's data word.
- R7: While the MSI-X enable is 0 or the function mask is 1, no message is sent and events stay pending. Once both allow sending, the pending messages go out and their pending bits clear.
- R8: An event on a masked vector sets its pending bit and sends nothing. Clearing the mask sends the message and clears the pending bit.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_hdr` and `tx_data` hold, even if the table is rewritten.
- R10: Among vectors eligible together, messages leave in ascending vector order.
- R11: Repeated events on a vector that is already pending produce a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_msix_en | input | 1 | MSI-X enable from message control |
| cfg_func_mask | input | 1 | Function-wide mask from message control |
| cfg_req_id | input | 16 | Requester ID placed in the header |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | DAW | Dword address (table, then pending dword) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_fire | input | NUM_VEC | One-cycle event per vector |
| tx_valid | output | 1 | Message available |
| tx_ready | input | 1 | Sink accepts message |
| tx_hdr | output | 128 | Request header, DW0 in bits 31:0 |
| tx_data | output | 32 | Single payload dword |

## Verification
The main function is driven with a low-memory vector and a high-memory vector, which separates the 3DW and 4DW header layouts. Events are raised under each gating condition in turn: enable off, function mask on, and vector mask on. This shows which gate holds a message back and that the pending state replays it. Two vectors fired together under a stalled sink show lowest-first order, and that the held output ignores table rewrites. Repeated events on a pending vector confirm that they merge into one message.

// File: rtl/msix_pkg.sv
package msix_pkg;

  localparam logic [2:0] FMT_3DW_DATA = 3'b010;
  localparam logic [2:0] FMT_4DW_DATA = 3'b011;
  localparam logic [4:0] TYPE_MEM     = 5'b00000;
  localparam logic [3:0] BE_FIRST     = 4'b1111;
  localparam logic [3:0] BE_LAST      = 4'b0000;
  localparam logic [9:0] LEN_ONE_DW   = 10'd1;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic        mask;
  } vec_entry_t;

  function automatic logic [127:0] build_hdr(vec_entry_t e, logic [15:0] req_id);
    logic [31:0] dw0, dw1, dw2, dw3;
    logic        wide;
    wide = (e.addr_hi != 32'd0);
    dw0  = {(wide ? FMT_4DW_DATA : FMT_3DW_DATA), TYPE_MEM, 14'd0, LEN_ONE_DW};
    dw1  = {req_id, 8'h00, BE_LAST, BE_FIRST};
    dw2  = wide ? e.addr_hi : e.addr_lo;
    dw3  = wide ? e.addr_lo : 32'd0;
    return {dw3, dw2, dw1, dw0};
  endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int DAW     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DAW-1:0]   addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output vec_entry_t       ent [NUM_VEC]
);

  localparam int VIW = DAW - 2;

  logic [VIW-1:0] vidx;
  logic [1:0]     word;

  assign vidx = addr[DAW-1:2];
  assign word = addr[1:0];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_slot
    logic hit;
    assign hit = wr_en && (int'(vidx) == v);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[v].addr_lo <= '0;
        ent[v].addr_hi <= '0;
        ent[v].data    <= '0;
        ent[v].mask    <= 1'b1;
      end else if (hit) begin
        case (word)
          2'd0:    ent[v].addr_lo <= {wdata[31:2], 2'b00};
          2'd1:    ent[v].addr_hi <= wdata;
          2'd2:    ent[v].data    <= wdata;
          default: ent[v].mask    <= wdata[0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (int'(vidx) == v) begin
        case (word)
          2'd0:    rdata = ent[v].addr_lo;
          2'd1:    rdata = ent[v].addr_hi;
          2'd2:    rdata = ent[v].data;
          default: rdata = {31'd0, ent[v].mask};
        endcase
      end
    end
  end

endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set,
  input  logic [NUM_VEC-1:0] clr,
  output logic [NUM_VEC-1:0] pend
);

  // A new event in the same cycle as a launch keeps the bit set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | set;
  end

endmodule

// File: rtl/msix_pick.sv
module msix_pick #(
  parameter int NUM_VEC = 4
) (
  input  logic [NUM_VEC-1:0] req,
  output logic [NUM_VEC-1:0] grant,
  output logic               any
);

  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (req[v] && !any) begin
        grant[v] = 1'b1;
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/msix_tx_reg.sv
module msix_tx_reg (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [127:0] hdr_in,
  input  logic [31:0]  data_in,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [127:0] tx_hdr,
  output logic [31:0]  tx_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_hdr   <= '0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_hdr   <= hdr_in;
      tx_data  <= data_in;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/msix_msg_gen.sv
module msix_msg_gen
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int DAW     = $clog2(NUM_VEC * 4 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_msix_en,
  input  logic               cfg_func_mask,
  input  logic [15:0]        cfg_req_id,
  input  logic               reg_wr,
  input  logic [DAW-1:0]     reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] irq_fire,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [127:0]       tx_hdr,
  output logic [31:0]        tx_data
);

  localparam int PBA_ADDR = NUM_VEC * 4;

  vec_entry_t         ent [NUM_VEC];
  logic [31:0]        tbl_rdata;
  logic [NUM_VEC-1:0] pend, vmask, eligible, grant, clr;
  logic               any, launch, fn_open, is_pba;
  vec_entry_t         sel;

  msix_vec_table #(.NUM_VEC(NUM_VEC), .DAW(DAW)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (tbl_rdata),
    .ent   (ent)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
    assign vmask[v] = ent[v].mask;
  end

  assign fn_open  = cfg_msix_en && !cfg_func_mask;
  assign eligible = pend & ~vmask & {NUM_VEC{fn_open}};

  msix_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .req   (eligible),
    .grant (grant),
    .any   (any)
  );

  assign launch = any && !tx_valid;
  assign clr    = launch ? grant : '0;

  msix_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_fire),
    .clr   (clr),
    .pend  (pend)
  );

  always_comb begin
    sel = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (grant[v]) sel = ent[v];
    end
  end

  msix_tx_reg u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .hdr_in   (build_hdr(sel, cfg_req_id)),
    .data_in  (sel.data),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_hdr   (tx_hdr),
    .tx_data  (tx_data)
  );

  assign is_pba = (int'(reg_addr) == PBA_ADDR);

  always_comb begin
    reg_rdata = tbl_rdata;
    if (is_pba) begin
      reg_rdata = '0;
      reg_rdata[NUM_VEC-1:0] = pend;
    end
  end

endmodule

// File: rtl/msix_msg_gen_chk.sv
module msix_msg_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_msix_en,
  input logic         cfg_func_mask,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic [127:0] tx_hdr,
  input logic [31:0]  tx_data
);

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_hdr) && $stable(tx_data));

  a_r4_byte_enables: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_hdr[39:32] == 8'h0F && tx_hdr[9:0] == 10'd1);

  a_r7_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(cfg_msix_en) && !$past(cfg_func_mask));

  a_r5_wide_has_hi: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_hdr[29] |-> tx_hdr[95:64] != 32'd0);

  a_r4_narrow_dw3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_hdr[29] |-> tx_hdr[127:96] == 32'd0);

endmodule

bind msix_msg_gen msix_msg_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_msix_en   (cfg_msix_en),
  .cfg_func_mask (cfg_func_mask),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_hdr        (tx_hdr),
  .tx_data       (tx_data)
);

// File: tb/test_msix_msg_gen.sv
`timescale 1ns/1ps
module test_msix_msg_gen;

  localparam int NV  = 4;
  localparam int DAW = $clog2(NV * 4 + 1);
  localparam int PBA = NV * 4;

  logic           clk = 0, rst_n = 0;
  logic           cfg_msix_en = 0, cfg_func_mask = 0;
  logic [15:0]    cfg_req_id = 16'hABCD;
  logic           reg_wr = 0;
  logic [DAW-1:0] reg_addr = '0;
  logic [31:0]    reg_wdata = '0, reg_rdata;
  logic [NV-1:0]  irq_fire = '0;
  logic           tx_valid, tx_ready = 1;
  logic [127:0]   tx_hdr;
  logic [31:0]    tx_data;

  int checks = 0, errors = 0;
  int mon_cnt = 0;
  logic [127:0] mon_hdr [16];
  logic [31:0]  mon_data [16];

  always #2 clk = ~clk;

  msix_msg_gen #(.NUM_VEC(NV)) i_msix_msg_gen (.*);

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && mon_cnt < 16) begin
      mon_hdr[mon_cnt]  = tx_hdr;
      mon_data[mon_cnt] = tx_data;
      mon_cnt++;
    end
  end

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = DAW'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = DAW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic fire(logic [NV-1:0] m);
    @(posedge clk); #1;
    irq_fire = m;
    @(posedge clk); #1;
    irq_fire = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "tx_valid", 128'(tx_valid), 128'(0));
    for (int v = 0; v < NV; v++) begin
      rd(4 * v + 3, d);
      chk("R1", "ctrl", 128'(d), 128'(1));
    end
    rd(PBA, d);
    chk("R1", "pba", 128'(d), 128'(0));
  endtask

  task automatic t_table_rw();
    logic [31:0] d;
    wr(4, 32'h1234_5677);
    rd(4, d); chk("R2", "addr_lo low bits", 128'(d), 128'(32'h1234_5674));
    wr(5, 32'hCAFE_0001);
    rd(5, d); chk("R2", "addr_hi", 128'(d), 128'(32'hCAFE_0001));
    wr(7, 32'hFFFF_FFFE);
    rd(7, d); chk("R2", "ctrl upper bits", 128'(d), 128'(0));
  endtask

  task automatic setup();
    wr(0, 32'hFEE0_0000); wr(1, 0);           wr(2, 32'h11); wr(3, 0);
    wr(4, 32'hFEE0_1000); wr(5, 0);           wr(6, 32'h22); wr(7, 0);
    wr(8, 32'h8000_0010); wr(9, 32'h1);       wr(10, 32'h33); wr(11, 0);
    wr(12, 32'hFEE0_3000); wr(13, 0);         wr(14, 32'h44); wr(15, 0);
    cfg_msix_en = 1;
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    mon_cnt = 0;
    fire(4'b0001); step(6);
    chk("R4", "count", 128'(mon_cnt), 128'(1));
    chk("R4", "dw0", 128'(mon_hdr[0][31:0]), 128'(32'h4000_0001));
    chk("R4", "dw1", 128'(mon_hdr[0][63:32]), 128'(32'hABCD_000F));
    chk("R4", "dw2", 128'(mon_hdr[0][95:64]), 128'(32'hFEE0_0000));
    chk("R4", "dw3", 128'(mon_hdr[0][127:96]), 128'(0));
    chk("R6", "payload", 128'(mon_data[0]), 128'(32'h11));
    rd(PBA, d); chk("R4", "pba cleared", 128'(d), 128'(0));
  endtask

  task automatic t_wide();
    mon_cnt = 0;
    fire(4'b0100); step(6);
    chk("R5", "count", 128'(mon_cnt), 128'(1));
    chk("R5", "dw0", 128'(mon_hdr[0][31:0]), 128'(32'h6000_0001));
    chk("R5", "dw2", 128'(mon_hdr[0][95:64]), 128'(32'h1));
    chk("R5", "dw3", 128'(mon_hdr[0][127:96]), 128'(32'h8000_0010));
    chk("R6", "payload", 128'(mon_data[0]), 128'(32'h33));
  endtask

  task automatic t_global_gate();
    logic [31:0] d;
    mon_cnt = 0;
    cfg_msix_en = 0;
    fire(4'b0010); step(6);
    chk("R7", "no send enable off", 128'(mon_cnt), 128'(0));
    rd(PBA, d); chk("R7", "pending", 128'(d), 128'(2));
    cfg_func_mask = 1; cfg_msix_en = 1; step(6);
    chk("R7", "no send func masked", 128'(mon_cnt), 128'(0));
    cfg_func_mask = 0; step(6);
    chk("R7", "replayed", 128'(mon_cnt), 128'(1));
    chk("R7", "replay data", 128'(mon_data[0]), 128'(32'h22));
    rd(PBA, d); chk("R7", "pending cleared", 128'(d), 128'(0));
  endtask

  task automatic t_vec_mask();
    logic [31:0] d;
    mon_cnt = 0;
    wr(15, 1);
    fire(4'b1000); step(6);
    chk("R8", "no send masked", 128'(mon_cnt), 128'(0));
    rd(PBA, d); chk("R8", "pending", 128'(d), 128'(8));
    wr(PBA, 0);
    rd(PBA, d); chk("R3", "pba write ignored", 128'(d), 128'(8));
    wr(15, 0); step(6);
    chk("R8", "sent on unmask", 128'(mon_cnt), 128'(1));
    chk("R8", "data", 128'(mon_data[0]), 128'(32'h44));
    rd(PBA, d); chk("R8", "pending cleared", 128'(d), 128'(0));
  endtask

  task automatic t_stall_order();
    mon_cnt = 0;
    tx_ready = 0;
    fire(4'b0011); step(2);
    wr(2, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) begin
      chk("R9", "valid held", 128'(tx_valid), 128'(1));
      chk("R9", "data held", 128'(tx_data), 128'(32'h11));
      step(1);
    end
    chk("R9", "nothing accepted", 128'(mon_cnt), 128'(0));
    tx_ready = 1; step(8);
    chk("R10", "count", 128'(mon_cnt), 128'(2));
    chk("R10", "first", 128'(mon_data[0]), 128'(32'h11));
    chk("R10", "second", 128'(mon_data[1]), 128'(32'h22));
    wr(2, 32'h11);
  endtask

  task automatic t_merge();
    mon_cnt = 0;
    cfg_msix_en = 0;
    fire(4'b0001); fire(4'b0001); fire(4'b0001);
    cfg_msix_en = 1; step(10);
    chk("R11", "single message", 128'(mon_cnt), 128'(1));
  endtask

  initial begin
    #1;
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_table_rw();
    setup();
    t_narrow();
    t_wide();
    t_global_gate();
    t_vec_mask();
    t_stall_order();
    t_merge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule